// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block puts one PS/2 keyboard or mouse port on a simple 32-bit peripheral bus. The bus uses word spacing, single-cycle read and write strobes, an address and write data, and it returns read data combinationally. The device side faces a separate serial engine through two byte interfaces. The receive interface carries a valid flag, a data byte and a pop strobe. The transmit interface carries a valid flag and a data byte.

Software sees these registers:
- a control word;
- a clock-divisor store;
- a status word;
- a data port that pops received bytes and sends bytes to transmit;
- an interrupt-status word;
- eight identification bytes at the top of the register space.

One level interrupt combines the receive-pending condition, gated by a control enable, with a control force bit that asserts it unconditionally.

Top module: `ps2reg_top`

## Requirements
- R1: After reset the control, clock-divisor and last-byte registers hold zero, and the interrupt and transmit-valid outputs are low.
- R2: Offset 0x00 is a read/write control register of CTRL_W bits. Write-data bits above CTRL_W are dropped, and they read back as zero.
- R3: Offset 0x0C is a read/write clock-divisor store of DIV_W bits. It has no effect on any other output.
- R4: Offset 0x04 reads 0x10 (only bit 4 set) while rxValid is high, and reads 0 otherwise.
- R5: A read of offset 0x08 while rxValid is high returns rxData in bits 7:0. In that same cycle rxPop goes high for exactly one cycle, and the byte is kept as the last byte.
- R6: A read of offset 0x08 while rxValid is low returns the last popped byte and leaves rxPop low.
- R7: Offset 0x10 reads rxValid in bit 0 and a constant 1 in bit 1. All other bits read as 0.
- R8: A write to offset 0x08 raises txValid for one cycle, in the cycle after the write, with txData equal to bits 7:0 of the write data.
- R9: irq equals (rxValid AND control bit 4) OR control bit 3. It follows a control write from the next cycle.
- R10: Reads of offsets 0xFE0 through 0xFFC return one byte per word, in the order 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of unmapped offsets return 0. Writes to unmapped offsets, or to offsets 0x04, 0x10 or the identification window, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busRead | input | 1 | Read strobe, one cycle per access |
| busWrite | input | 1 | Write strobe, one cycle per access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the read cycle |
| rxValid | input | 1 | Received byte waiting in the serial engine |
| rxData | input | 8 | Waiting received byte |
| rxPop | output | 1 | Consumes the waiting byte |
| txValid | output | 1 | Byte offered to the serial engine |
| txData | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 32-bit data word, and 8-bit control and divisor registers. With these values the identification window falls at 0xFE0, so all eight identification bytes can be reached. The 8-bit control width lets a write with ones in the upper bits show that those bits are dropped. The table-driven pass covers every register under both pending states. The directed tests then check the one-cycle pop and transmit pulses, and both the gated and the forced interrupt paths.

// File: rtl/ps2reg_pkg.sv
package ps2reg_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_DIV, SEL_ISTAT, SEL_ID
  } readSel_t;

  typedef struct packed {
    logic      wrCtrl;
    logic      wrDiv;
    logic      wrData;
    logic      popRx;
    readSel_t  readSel;
    logic [2:0] idIdx;
  } strobe_t;

  localparam int W_CTRL  = 0;
  localparam int W_STAT  = 1;
  localparam int W_DATA  = 2;
  localparam int W_DIV   = 3;
  localparam int W_ISTAT = 4;

  function automatic logic [7:0] idByte(input logic [2:0] idx);
    case (idx)
      3'd0: idByte = 8'h50;
      3'd1: idByte = 8'h10;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/ps2reg_ctrl.sv
module ps2reg_ctrl
  import ps2reg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic              rxValid,
  output strobe_t           strb
);
  localparam int WIDX_W  = ADDR_W - 2;
  localparam int ID_BASE = (1 << WIDX_W) - 8;

  logic [WIDX_W-1:0] wordIdx;
  readSel_t          sel;

  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    sel = SEL_NONE;
    if (int'(wordIdx) >= ID_BASE) sel = SEL_ID;
    else if (int'(wordIdx) == W_CTRL)  sel = SEL_CTRL;
    else if (int'(wordIdx) == W_STAT)  sel = SEL_STAT;
    else if (int'(wordIdx) == W_DATA)  sel = SEL_DATA;
    else if (int'(wordIdx) == W_DIV)   sel = SEL_DIV;
    else if (int'(wordIdx) == W_ISTAT) sel = SEL_ISTAT;
  end

  always_comb begin
    strb         = '0;
    strb.readSel = sel;
    strb.idIdx   = wordIdx[2:0];
    strb.wrCtrl  = busWrite && (sel == SEL_CTRL);
    strb.wrDiv   = busWrite && (sel == SEL_DIV);
    strb.wrData  = busWrite && (sel == SEL_DATA);
    strb.popRx   = busRead && (sel == SEL_DATA) && rxValid;
  end

  // R5
  pop_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.popRx |-> (busRead && rxValid));

  // R11
  one_write_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtrl, strb.wrDiv, strb.wrData}));
endmodule

// File: rtl/ps2reg_dp.sv
module ps2reg_dp
  import ps2reg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              irq
);
  localparam int IRQ_EN_BIT    = 4;
  localparam int IRQ_FORCE_BIT = 3;
  localparam int STAT_RX_BIT   = 4;

  logic [CTRL_W-1:0] ctrlReg;
  logic [DIV_W-1:0]  divReg;
  logic [7:0]        lastByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      divReg   <= '0;
      lastByte <= '0;
      txValid  <= 1'b0;
      txData   <= '0;
    end else begin
      if (strb.wrCtrl) ctrlReg <= busWdata[CTRL_W-1:0];
      if (strb.wrDiv)  divReg  <= busWdata[DIV_W-1:0];
      if (strb.popRx)  lastByte <= rxData;
      txValid <= strb.wrData;
      if (strb.wrData) txData <= busWdata[7:0];
    end
  end

  assign irq = (rxValid && ctrlReg[IRQ_EN_BIT]) || ctrlReg[IRQ_FORCE_BIT];

  always_comb begin
    busRdata = '0;
    case (strb.readSel)
      SEL_CTRL:  busRdata[CTRL_W-1:0] = ctrlReg;
      SEL_DIV:   busRdata[DIV_W-1:0]  = divReg;
      SEL_STAT:  busRdata[STAT_RX_BIT] = rxValid;
      SEL_DATA:  busRdata[7:0] = rxValid ? rxData : lastByte;
      SEL_ISTAT: busRdata[1:0] = {1'b1, rxValid};
      SEL_ID:    busRdata[7:0] = idByte(strb.idIdx);
      default:   busRdata = '0;
    endcase
  end

  // R8
  tx_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(strb.wrData));

  // R6
  last_byte_on_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lastByte) |-> $past(strb.popRx));

  // R2
  ctrl_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlReg) |-> $past(strb.wrCtrl));

  // R3
  div_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divReg) |-> $past(strb.wrDiv));
endmodule

// File: rtl/ps2reg_top.sv
module ps2reg_top
  import ps2reg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxPop,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              irq
);
  strobe_t strb;

  ps2reg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .rxValid(rxValid), .strb(strb)
  );

  ps2reg_dp #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txData(txData), .irq(irq)
  );

  assign rxPop = strb.popRx;

  // R1
  tx_low_after_reset_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (!txValid && !irq));
endmodule

// File: tb/ps2reg_top_test.sv
module ps2reg_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        rxPop, txValid, irq;
  logic [7:0]  txData;

  int applied = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ps2reg_top uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .rxValid(rxValid), .rxData(rxData), .rxPop(rxPop),
    .txValid(txValid), .txData(txData), .irq(irq)
  );

  typedef struct packed {
    logic        isWrite;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        rxV;
    logic [7:0]  rxD;
    logic [31:0] expect_;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 32'hFFFF_FF1F, 1'b0, 8'h00, 32'h0, 8'd2},   // R2 write
    '{1'b0, 12'h000, 32'h0, 1'b0, 8'h00, 32'h0000_001F, 8'd2},   // R2 read
    '{1'b1, 12'h00C, 32'h0000_00AB, 1'b0, 8'h00, 32'h0, 8'd3},   // R3 write
    '{1'b0, 12'h00C, 32'h0, 1'b0, 8'h00, 32'h0000_00AB, 8'd3},   // R3 read
    '{1'b0, 12'h004, 32'h0, 1'b1, 8'h00, 32'h0000_0010, 8'd4},   // R4
    '{1'b0, 12'h004, 32'h0, 1'b0, 8'h00, 32'h0, 8'd4},           // R4
    '{1'b0, 12'h010, 32'h0, 1'b0, 8'h00, 32'h0000_0002, 8'd7},   // R7
    '{1'b0, 12'h010, 32'h0, 1'b1, 8'h00, 32'h0000_0003, 8'd7},   // R7
    '{1'b0, 12'h008, 32'h0, 1'b1, 8'h5A, 32'h0000_005A, 8'd5},   // R5
    '{1'b0, 12'h008, 32'h0, 1'b0, 8'h77, 32'h0000_005A, 8'd6},   // R6
    '{1'b0, 12'hFE0, 32'h0, 1'b0, 8'h00, 32'h0000_0050, 8'd10},  // R10
    '{1'b0, 12'hFE4, 32'h0, 1'b0, 8'h00, 32'h0000_0010, 8'd10},
    '{1'b0, 12'hFE8, 32'h0, 1'b0, 8'h00, 32'h0000_0004, 8'd10},
    '{1'b0, 12'hFEC, 32'h0, 1'b0, 8'h00, 32'h0000_0000, 8'd10},
    '{1'b0, 12'hFF0, 32'h0, 1'b0, 8'h00, 32'h0000_000D, 8'd10},
    '{1'b0, 12'hFF4, 32'h0, 1'b0, 8'h00, 32'h0000_00F0, 8'd10},
    '{1'b0, 12'hFF8, 32'h0, 1'b0, 8'h00, 32'h0000_0005, 8'd10},
    '{1'b0, 12'hFFC, 32'h0, 1'b0, 8'h00, 32'h0000_00B1, 8'd10},
    '{1'b0, 12'h014, 32'h0, 1'b1, 8'h00, 32'h0, 8'd11},          // R11 unmapped
    '{1'b0, 12'h800, 32'h0, 1'b1, 8'h00, 32'h0, 8'd11},
    '{1'b1, 12'h004, 32'hFFFF_FFFF, 1'b0, 8'h00, 32'h0, 8'd11},
    '{1'b0, 12'h004, 32'h0, 1'b0, 8'h00, 32'h0, 8'd11},
    '{1'b1, 12'h010, 32'hFFFF_FFFF, 1'b0, 8'h00, 32'h0, 8'd11},
    '{1'b0, 12'h010, 32'h0, 1'b0, 8'h00, 32'h0000_0002, 8'd11},
    '{1'b1, 12'h800, 32'h0000_0000, 1'b0, 8'h00, 32'h0, 8'd11},
    '{1'b1, 12'hFE0, 32'h0000_0000, 1'b0, 8'h00, 32'h0, 8'd11},
    '{1'b0, 12'h000, 32'h0, 1'b0, 8'h00, 32'h0000_001F, 8'd11}   // R11 control kept
  };

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one bus cycle at the falling edge; sample combinational outputs 2 ns later.
  task automatic busCycle(input logic wr, input logic rd, input logic [11:0] a,
                          input logic [31:0] wd, input logic rv, input logic [7:0] rd8);
    @(negedge clk);
    busWrite = wr; busRead = rd; busAddr = a; busWdata = wd;
    rxValid = rv; rxData = rd8;
    #2;
  endtask

  task automatic idle(input logic rv);
    busCycle(1'b0, 1'b0, 12'h000, 32'h0, rv, 8'h00);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #2;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 txValid", {31'b0, txValid}, 32'h0);
    busCycle(1'b0, 1'b1, 12'h000, 32'h0, 1'b0, 8'h00);
    check("R1 ctrl", busRdata, 32'h0);
    busCycle(1'b0, 1'b1, 12'h00C, 32'h0, 1'b0, 8'h00);
    check("R1 div", busRdata, 32'h0);
    busCycle(1'b0, 1'b1, 12'h008, 32'h0, 1'b0, 8'h00);
    check("R1 lastByte", busRdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      busCycle(VECS[i].isWrite, !VECS[i].isWrite, VECS[i].addr, VECS[i].wdata,
               VECS[i].rxV, VECS[i].rxD);
      if (!VECS[i].isWrite)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), busRdata, VECS[i].expect_);
    end
    idle(1'b0);

    // R5 pop pulse exactly in the read cycle
    busCycle(1'b0, 1'b1, 12'h008, 32'h0, 1'b1, 8'hC6);
    check("R5 pop high", {31'b0, rxPop}, 32'h1);
    check("R5 data", busRdata, 32'h0000_00C6);
    idle(1'b1);
    check("R5 pop one cycle", {31'b0, rxPop}, 32'h0);
    // R6 no pop when nothing waits
    busCycle(1'b0, 1'b1, 12'h008, 32'h0, 1'b0, 8'h11);
    check("R6 pop low", {31'b0, rxPop}, 32'h0);
    check("R6 last byte", busRdata, 32'h0000_00C6);

    // R8 transmit pulse
    busCycle(1'b1, 1'b0, 12'h008, 32'h1234_56C3, 1'b0, 8'h00);
    check("R8 no tx in write cycle", {31'b0, txValid}, 32'h0);
    idle(1'b0);
    check("R8 txValid", {31'b0, txValid}, 32'h1);
    check("R8 txData", {24'b0, txData}, 32'h0000_00C3);
    idle(1'b0);
    check("R8 tx one cycle", {31'b0, txValid}, 32'h0);

    // R9 interrupt: gated pending path
    busCycle(1'b1, 1'b0, 12'h000, 32'h0000_0010, 1'b0, 8'h00);
    idle(1'b0);
    check("R9 enabled no pending", {31'b0, irq}, 32'h0);
    idle(1'b1);
    check("R9 enabled pending", {31'b0, irq}, 32'h1);
    // R9 forced path
    busCycle(1'b1, 1'b0, 12'h000, 32'h0000_0008, 1'b0, 8'h00);
    idle(1'b0);
    check("R9 forced", {31'b0, irq}, 32'h1);
    busCycle(1'b1, 1'b0, 12'h000, 32'h0000_0000, 1'b1, 8'h00);
    idle(1'b1);
    check("R9 disabled pending", {31'b0, irq}, 32'h0);

    // R3 divisor has no side effect on irq or tx
    busCycle(1'b1, 1'b0, 12'h00C, 32'h0000_00FF, 1'b1, 8'h00);
    idle(1'b1);
    check("R3 irq unaffected", {31'b0, irq}, 32'h0);
    check("R3 tx unaffected", {31'b0, txValid}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule